// File: doc/BRIEF.md
# Synchronous Serial Port Register Bank

This block is the software-visible face of a synchronous serial port controller. It decodes a 32-bit word-addressed bus with separate read and write strobes inside a 4 KB window. It holds the configuration state that the serial engine uses: two control words, an even clock divisor and DMA enables. It also turns bus accesses to the data offset into push and pop strobes for the transmit and receive FIFOs, which sit outside this block.

An interrupt unit turns single-cycle event pulses from the engine into sticky pending bits. Software sees those bits through a raw view, an enable mask and a masked view, and it clears them by writing ones. A single interrupt line reports that some enabled source is pending. Fixed identification bytes sit at the top of the window. The shifter, the FIFO storage and the bit-rate generator are not part of this block.

Reads are combinational: `bus_rdata` is valid in the same cycle as `bus_rd`, and it is zero when no read is active. A write takes effect at the clock edge that ends the write cycle. Addresses are byte addresses, and bits [1:0] are ignored.

Top module: `syncser_regs`

## Requirements
- R1: After reset the control words, divisor, DMA enables, interrupt mask and pending bits all read as zero, and `irq_out` is low.
- R2: Control word A (offset 0x00, 16 bits), control word B (0x04, 4 bits) and the DMA enables (0x24, 2 bits) read back the last written value in their low bits, with all higher bits reading zero.
- R3: The divisor register (0x10, 8 bits) reads back the written value with bit 0 forced to zero.
- R4: A write to the data offset (0x08) pulses `tx_push` in that cycle. `tx_data` then carries the written value with every bit above the frame width cleared. The frame width is control word A bits [3:0] plus one.
- R5: A read of the data offset pulses `rx_pop` in that cycle. The read returns `rx_data` with every bit above the frame width cleared.
- R6: A read of offset 0x0C returns `stat_in` in its low 5 bits.
- R7: An event pulse on `irq_evt[i]` sets pending bit i. The bit stays set until it is cleared. Pending bits read at offset 0x18.
- R8: Writing to offset 0x20 clears each pending bit whose data bit is 1 and leaves the others unchanged. An event in the same cycle as the clear wins, so the bit stays set.
- R9: The mask register (0x14) reads back the last written 4 bits. Offset 0x1C reads the pending bits ANDed with the mask.
- R10: `irq_out` is high exactly when some pending bit is set and its mask bit is 1.
- R11: Writes to the status, pending, masked, ID and unmapped offsets change nothing. Reads of the clear offset and of unmapped offsets return zero.
- R12: Byte reads at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return the peripheral ID parameter, least significant byte first. Reads at 0xFF0 through 0xFFC return 0x0D, 0xF0, 0x05 and 0xB1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address in the 4 KB window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| stat_in | input | 5 | FIFO level and busy flags from the engine |
| rx_data | input | 16 | Head entry of the receive FIFO |
| irq_evt | input | 4 | Single-cycle interrupt event pulses |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_data | output | 16 | Transmit entry, trimmed to the frame width |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| ctl_a | output | 16 | Control word A |
| ctl_b | output | 4 | Control word B |
| clk_div | output | 8 | Even clock divisor |
| dma_en | output | 2 | DMA enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench mixes seeded random accesses over mapped, read-only and unmapped offsets with random event bursts, and compares every read against a model. A random write followed by a read-back separates correct register storage from writes that leak to read-only or unmapped offsets. Event pulses that arrive together with clear writes, and clears with zero data bits, tell apart the "set wins" rule from clear priority. Data-port accesses under several frame widths separate correct right-justified trimming from pass-through, and rising and falling mask bits show whether `irq_out` follows the masked view and not the raw one.

// File: rtl/syncser_pkg.sv
package syncser_pkg;
  localparam int WIDX_W = 10;
  typedef logic [WIDX_W-1:0] widx_t;
  localparam widx_t W_CTLA = 10'h000;
  localparam widx_t W_CTLB = 10'h001;
  localparam widx_t W_DATA = 10'h002;
  localparam widx_t W_STAT = 10'h003;
  localparam widx_t W_DIV  = 10'h004;
  localparam widx_t W_MASK = 10'h005;
  localparam widx_t W_RAW  = 10'h006;
  localparam widx_t W_MSKD = 10'h007;
  localparam widx_t W_CLR  = 10'h008;
  localparam widx_t W_DMA  = 10'h009;
  localparam logic [7:0] PID_GRP = 8'hFE;
  localparam logic [7:0] CID_GRP = 8'hFF;
  localparam logic [31:0] CELL_ID = 32'hB105_F00D;
endpackage

// File: rtl/syncser_cfg_regs.sv
module syncser_cfg_regs
  import syncser_pkg::*;
#(
  parameter int CTLA_W = 16,
  parameter int CTLB_W = 4,
  parameter int DIV_W  = 8,
  parameter int DMA_W  = 2,
  parameter int IRQ_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  widx_t             widx,
  input  logic [31:0]       wdata,
  output logic [CTLA_W-1:0] ctl_a_q,
  output logic [CTLB_W-1:0] ctl_b_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [DMA_W-1:0]  dma_q,
  output logic [IRQ_N-1:0]  mask_q
);
  logic [CTLA_W-1:0] ctl_a_d;
  logic [CTLB_W-1:0] ctl_b_d;
  logic [DIV_W-1:0]  div_d;
  logic [DMA_W-1:0]  dma_d;
  logic [IRQ_N-1:0]  mask_d;

  always_comb begin
    ctl_a_d = ctl_a_q;
    ctl_b_d = ctl_b_q;
    div_d   = div_q;
    dma_d   = dma_q;
    mask_d  = mask_q;
    if (wr_en) begin
      case (widx)
        W_CTLA:  ctl_a_d = wdata[CTLA_W-1:0];
        W_CTLB:  ctl_b_d = wdata[CTLB_W-1:0];
        W_DIV:   div_d   = {wdata[DIV_W-1:1], 1'b0};
        W_DMA:   dma_d   = wdata[DMA_W-1:0];
        W_MASK:  mask_d  = wdata[IRQ_N-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_a_q <= '0;
      ctl_b_q <= '0;
      div_q   <= '0;
      dma_q   <= '0;
      mask_q  <= '0;
    end else if (wr_en) begin
      ctl_a_q <= ctl_a_d;
      ctl_b_q <= ctl_b_d;
      div_q   <= div_d;
      dma_q   <= dma_d;
      mask_q  <= mask_d;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;
endmodule

// File: rtl/syncser_irq.sv
module syncser_irq #(
  parameter int IRQ_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] evt,
  input  logic [IRQ_N-1:0] clr_bits,
  input  logic [IRQ_N-1:0] mask,
  output logic [IRQ_N-1:0] raw_q,
  output logic [IRQ_N-1:0] masked,
  output logic             irq
);
  logic [IRQ_N-1:0] raw_d;
  logic             upd_en;

  // a new event beats a clear landing in the same cycle
  always_comb begin
    raw_d  = (raw_q & ~clr_bits) | evt;
    upd_en = (|evt) | (|clr_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (upd_en) raw_q <= raw_d;
  end

  assign masked = raw_q & mask;
  assign irq    = |masked;
endmodule

// File: rtl/syncser_frame_mask.sv
module syncser_frame_mask #(
  parameter int DATA_W = 16,
  localparam int SZ_W  = $clog2(DATA_W)
) (
  input  logic [SZ_W-1:0]   size_m1,
  output logic [DATA_W-1:0] keep
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    assign keep[i] = (SZ_W'(i) <= size_m1);
  end
endmodule

// File: rtl/syncser_rdmux.sv
module syncser_rdmux
  import syncser_pkg::*;
#(
  parameter int          CTLA_W    = 16,
  parameter int          CTLB_W    = 4,
  parameter int          DIV_W     = 8,
  parameter int          DMA_W     = 2,
  parameter int          IRQ_N     = 4,
  parameter int          STAT_W    = 5,
  parameter int          DATA_W    = 16,
  parameter logic [31:0] PERIPH_ID = 32'h0013_C0A7
) (
  input  widx_t             widx,
  input  logic [CTLA_W-1:0] ctl_a,
  input  logic [CTLB_W-1:0] ctl_b,
  input  logic [DIV_W-1:0]  div,
  input  logic [DMA_W-1:0]  dma,
  input  logic [IRQ_N-1:0]  mask,
  input  logic [IRQ_N-1:0]  raw,
  input  logic [IRQ_N-1:0]  masked,
  input  logic [STAT_W-1:0] stat,
  input  logic [DATA_W-1:0] rx_trim,
  output logic [31:0]       rd
);
  always_comb begin
    rd = '0;
    case (widx)
      W_CTLA: rd[CTLA_W-1:0] = ctl_a;
      W_CTLB: rd[CTLB_W-1:0] = ctl_b;
      W_DATA: rd[DATA_W-1:0] = rx_trim;
      W_STAT: rd[STAT_W-1:0] = stat;
      W_DIV:  rd[DIV_W-1:0]  = div;
      W_MASK: rd[IRQ_N-1:0]  = mask;
      W_RAW:  rd[IRQ_N-1:0]  = raw;
      W_MSKD: rd[IRQ_N-1:0]  = masked;
      W_DMA:  rd[DMA_W-1:0]  = dma;
      default: begin
        if (widx[9:2] == PID_GRP)      rd[7:0] = PERIPH_ID[8*widx[1:0] +: 8];
        else if (widx[9:2] == CID_GRP) rd[7:0] = CELL_ID[8*widx[1:0] +: 8];
      end
    endcase
  end
endmodule

// File: rtl/syncser_regs.sv
module syncser_regs
  import syncser_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          IRQ_N     = 4,
  parameter int          STAT_W    = 5,
  parameter int          CTLA_W    = 16,
  parameter int          CTLB_W    = 4,
  parameter int          DIV_W     = 8,
  parameter int          DMA_W     = 2,
  parameter logic [31:0] PERIPH_ID = 32'h0013_C0A7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [STAT_W-1:0] stat_in,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [IRQ_N-1:0]  irq_evt,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_data,
  output logic              rx_pop,
  output logic [CTLA_W-1:0] ctl_a,
  output logic [CTLB_W-1:0] ctl_b,
  output logic [DIV_W-1:0]  clk_div,
  output logic [DMA_W-1:0]  dma_en,
  output logic              irq_out
);
  localparam int SZ_W = $clog2(DATA_W);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  widx_t            widx;
  logic [IRQ_N-1:0] clr_bits;
  logic [IRQ_N-1:0] raw_st;
  logic [IRQ_N-1:0] mask_st;
  logic [IRQ_N-1:0] masked_st;
  logic [DATA_W-1:0] keep;
  logic [31:0]      rd_mux;

  assign widx     = bus_addr[11:2];
  assign clr_bits = (bus_wr && widx == W_CLR) ? bus_wdata[IRQ_N-1:0] : '0;

  syncser_cfg_regs #(
    .CTLA_W(CTLA_W), .CTLB_W(CTLB_W), .DIV_W(DIV_W), .DMA_W(DMA_W), .IRQ_N(IRQ_N)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bus_wr), .widx(widx), .wdata(bus_wdata),
    .ctl_a_q(ctl_a), .ctl_b_q(ctl_b), .div_q(clk_div), .dma_q(dma_en), .mask_q(mask_st)
  );

  syncser_irq #(.IRQ_N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .evt(irq_evt), .clr_bits(clr_bits), .mask(mask_st),
    .raw_q(raw_st), .masked(masked_st), .irq(irq_out)
  );

  syncser_frame_mask #(.DATA_W(DATA_W)) u_fmask (
    .size_m1(ctl_a[SZ_W-1:0]), .keep(keep)
  );

  syncser_rdmux #(
    .CTLA_W(CTLA_W), .CTLB_W(CTLB_W), .DIV_W(DIV_W), .DMA_W(DMA_W), .IRQ_N(IRQ_N),
    .STAT_W(STAT_W), .DATA_W(DATA_W), .PERIPH_ID(PERIPH_ID)
  ) u_rdmux (
    .widx(widx), .ctl_a(ctl_a), .ctl_b(ctl_b), .div(clk_div), .dma(dma_en),
    .mask(mask_st), .raw(raw_st), .masked(masked_st), .stat(stat_in),
    .rx_trim(rx_data & keep), .rd(rd_mux)
  );

  assign tx_push   = bus_wr && (widx == W_DATA);
  assign tx_data   = bus_wdata[DATA_W-1:0] & keep;
  assign rx_pop    = bus_rd && (widx == W_DATA);
  assign bus_rdata = bus_rd ? rd_mux : '0;

  logic unused_addr;
  assign unused_addr = ^bus_addr[1:0];
endmodule

// File: rtl/syncser_regs_chk.sv
module syncser_regs_chk #(
  parameter int IRQ_N = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [11:0]      bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [31:0]      bus_rdata,
  input logic [IRQ_N-1:0] irq_evt,
  input logic [IRQ_N-1:0] raw_st,
  input logic [IRQ_N-1:0] mask_st,
  input logic             tx_push,
  input logic             rx_pop,
  input logic             irq_out
);
  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr[11:2] == 10'h008);

  p_evt_sets_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|irq_evt) |=> ((raw_st & $past(irq_evt)) == $past(irq_evt)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clr_wr |=> ((raw_st & $past(raw_st)) == $past(raw_st)));

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_out |-> ((raw_st & mask_st) != '0));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (raw_st == '0) |-> !irq_out);

  p_push_on_write_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_push |-> bus_wr);

  p_pop_on_read_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_pop |-> bus_rd);

  p_div_even_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_addr[11:2] == 10'h004) |-> !bus_rdata[0]);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

bind syncser_regs syncser_regs_chk #(.IRQ_N(IRQ_N)) u_chk (.*);

// File: tb/syncser_regs_bench.sv
`timescale 1ns/1ps
module syncser_regs_bench;
  localparam int IRQ_N = 4;
  localparam logic [31:0] PID = 32'h0013_C0A7;
  localparam logic [31:0] CID = 32'hB105_F00D;

  logic        clk, rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [4:0]  stat_in;
  logic [15:0] rx_data, tx_data, ctl_a;
  logic [IRQ_N-1:0] irq_evt;
  logic        tx_push, rx_pop, irq_out;
  logic [3:0]  ctl_b;
  logic [7:0]  clk_div;
  logic [1:0]  dma_en;

  syncser_regs u_syncser_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat_in(stat_in), .rx_data(rx_data),
    .irq_evt(irq_evt), .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .clk_div(clk_div), .dma_en(dma_en), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [15:0] m_ctla;
  logic [3:0]  m_ctlb, m_mask, m_raw;
  logic [7:0]  m_div;
  logic [1:0]  m_dma;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] fmask(input logic [3:0] sz);
    logic [15:0] k = '0;
    for (int i = 0; i < 16; i++) if (i <= int'(sz)) k[i] = 1'b1;
    return k;
  endfunction

  function automatic logic [31:0] exp_read(input logic [9:0] w);
    logic [31:0] v = '0;
    case (w)
      10'h000: v[15:0] = m_ctla;
      10'h001: v[3:0]  = m_ctlb;
      10'h002: v[15:0] = rx_data & fmask(m_ctla[3:0]);
      10'h003: v[4:0]  = stat_in;
      10'h004: v[7:0]  = m_div;
      10'h005: v[3:0]  = m_mask;
      10'h006: v[3:0]  = m_raw;
      10'h007: v[3:0]  = m_raw & m_mask;
      10'h009: v[1:0]  = m_dma;
      default: begin
        if (w[9:2] == 8'hFE)      v[7:0] = PID[8*w[1:0] +: 8];
        else if (w[9:2] == 8'hFF) v[7:0] = CID[8*w[1:0] +: 8];
      end
    endcase
    return v;
  endfunction

  function automatic string tag_of(input logic [9:0] w);
    case (w)
      10'h000, 10'h001, 10'h009: return "R2";
      10'h002: return "R5";
      10'h003: return "R6";
      10'h004: return "R3";
      10'h005, 10'h007: return "R9";
      10'h006: return "R7";
      default: return (w[9:3] == 7'h7F) ? "R12" : "R11";
    endcase
  endfunction

  task automatic cyc(input logic wr, input logic rd, input logic [11:0] a,
                     input logic [31:0] d, input logic [IRQ_N-1:0] ev, input string ovr);
    logic [9:0] w = a[11:2];
    logic [3:0] clr;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; irq_evt = ev;
    stat_in = 5'($urandom); rx_data = 16'($urandom);
    #1;
    chk(ovr != "" ? ovr : tag_of(w), bus_rdata, rd ? exp_read(w) : 32'h0);
    chk("R4", {31'h0, tx_push}, {31'h0, wr && w == 10'h002});
    if (wr && w == 10'h002) chk("R4", {16'h0, tx_data}, {16'h0, d[15:0] & fmask(m_ctla[3:0])});
    chk("R5", {31'h0, rx_pop}, {31'h0, rd && w == 10'h002});
    chk(ovr != "" ? ovr : "R10", {31'h0, irq_out}, {31'h0, |(m_raw & m_mask)});
    @(posedge clk);
    clr = (wr && w == 10'h008) ? d[3:0] : 4'h0;
    if (wr) case (w)
      10'h000: m_ctla = d[15:0];
      10'h001: m_ctlb = d[3:0];
      10'h004: m_div  = {d[7:1], 1'b0};
      10'h005: m_mask = d[3:0];
      10'h009: m_dma  = d[1:0];
      default: ;
    endcase
    m_raw = (m_raw & ~clr) | ev;
  endtask

  task automatic rd_at(input logic [11:0] a, input string t);
    cyc(1'b0, 1'b1, a, 32'h0, '0, t);
  endtask
  task automatic wr_at(input logic [11:0] a, input logic [31:0] d, input logic [IRQ_N-1:0] ev);
    cyc(1'b1, 1'b0, a, d, ev, "");
  endtask

  logic [11:0] alist [20] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
    12'h018, 12'h01C, 12'h020, 12'h024, 12'h028, 12'h100, 12'hFDC, 12'hFE0,
    12'hFE4, 12'hFEC, 12'hFF0, 12'hFF4, 12'hFF8, 12'hFFC};

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_ctla = '0; m_ctlb = '0; m_mask = '0; m_raw = '0; m_div = '0; m_dma = '0;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; irq_evt = '0;
    stat_in = '0; rx_data = '0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    // R1: reset state of every writable register and the pending bits
    foreach (alist[i]) if (alist[i] < 12'h028) rd_at(alist[i], "R1");
    chk("R1", {31'h0, irq_out}, 32'h0);
    // R3: odd divisor reads back even
    wr_at(12'h010, 32'h0000_00FF, '0); rd_at(12'h010, "R3");
    wr_at(12'h010, 32'h0000_0003, '0); rd_at(12'h010, "R3");
    // R4/R5: 4-bit, 8-bit and 16-bit frames
    wr_at(12'h000, 32'h0000_0003, '0); wr_at(12'h008, 32'hFFFF_FFFF, '0); rd_at(12'h008, "R5");
    wr_at(12'h000, 32'h0000_0007, '0); wr_at(12'h008, 32'h0000_ABCD, '0); rd_at(12'h008, "R5");
    wr_at(12'h000, 32'h0000_000F, '0); wr_at(12'h008, 32'h1234_5678, '0); rd_at(12'h008, "R5");
    // R7/R8: sticky set, zero clear ignored, set wins over clear
    wr_at(12'h014, 32'h0000_0005, 4'b0011); rd_at(12'h018, "R7");
    wr_at(12'h020, 32'h0000_0000, '0); rd_at(12'h018, "R8");
    wr_at(12'h020, 32'h0000_0003, 4'b0010); rd_at(12'h018, "R8");
    rd_at(12'h01C, "R9");
    wr_at(12'h020, 32'h0000_000F, '0); rd_at(12'h018, "R8");
    // R11: writes to read-only offsets leave state untouched
    wr_at(12'h018, 32'hFFFF_FFFF, '0); wr_at(12'h01C, 32'hFFFF_FFFF, '0);
    wr_at(12'h028, 32'hFFFF_FFFF, '0); rd_at(12'h018, "R11"); rd_at(12'h020, "R11");
    // R12: identification bytes
    for (int k = 0; k < 8; k++) rd_at(12'hFE0 + 12'(4 * k), "R12");
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a = alist[$urandom_range(0, 19)];
      logic [IRQ_N-1:0] ev = ($urandom_range(0, 3) == 0) ? 4'($urandom) : '0;
      case ($urandom_range(0, 2))
        0: cyc(1'b1, 1'b0, a, $urandom, ev, "");
        1: cyc(1'b0, 1'b1, a, 32'h0, ev, "");
        default: cyc(1'b0, 1'b0, 12'h0, 32'h0, ev, "");
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule